// File: doc/BRIEF.md
# GPIO interrupt detection controller

This block watches a bank of general-purpose input pins and turns chosen activity on them into interrupt requests. Each pin has its own trigger mode. The mode can be a rising edge, a falling edge, either edge, a high level or a low level. Every pin input passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier.

A detected event latches a per-pin pending bit. Pending bits are latched whether or not the pin is masked. A single registered interrupt line is raised whenever any pending bit belongs to an unmasked pin. Software scans the pending register and acknowledges each bit by writing a one to it. Masks are changed only through separate write-one set and clear registers, so no read-modify-write cycle is needed.

All registers sit on a simple synchronous word-addressed bus. The register offsets are:

| Offset | Register |
|---|---|
| 0 | enable |
| 1 | pending (read-only) |
| 2 | acknowledge |
| 3 | mask readback |
| 4 | mask set |
| 5 | mask clear |
| 6 | mode bank 0 |
| 7 | mode bank 1 |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the pending register reads 0, the mask readback has all NPINS bits set, both mode banks read 0 and `irq_o` is low. Read data appears on `bus_rdata` one clock edge after the address is presented; unused upper bits read 0.
- R2: Mode code 1 (rising) sets pin n's pending bit on a 0-to-1 change of the pin and not on a 1-to-0 change.
- R3: Mode code 0 (falling) sets the pending bit on a 1-to-0 change and not on a 0-to-1 change.
- R4: Mode code 4 (both edges) sets the pending bit on either change of the pin.
- R5: Mode code 3 (high level) and code 2 (low level) set the pending bit on every cycle that the pin sits at its active level. An acknowledge therefore only sticks once the pin has left that level.
- R6: Mode codes 5, 6 and 7 never set a pending bit.
- R7: The enable register (offset 0, bit n for pin n) is readable and writable. A pin whose enable bit is 0 never sets its pending bit.
- R8: Writing 1 to bit n of the acknowledge register (offset 2) clears pending bit n. Bits written as 0 leave their pending bits unchanged.
- R9: Writing 1 to bit n at offset 4 masks pin n, and writing 1 to bit n at offset 5 unmasks it. Zero bits leave the mask unchanged. The mask reads back at offset 3.
- R10: `irq_o` is the registered OR of (pending AND NOT mask) over all pins. Pending bits latch even on masked pins. For an enabled, unmasked pin, `irq_o` rises on the fourth rising clock edge after the pin input changes.
- R11: When a detected event and an acknowledge write hit the same pending bit in the same cycle, the bit ends up set.
- R12: Pin n's mode is the 3-bit code in bits [2:0] of a 4-bit field. For n < 8 the field sits at bit 4·n of mode bank 0 (offset 6). For n ≥ 8 it sits at bit 4·(n−8) of mode bank 1 (offset 7). Field bit 3, and fields of pins that do not exist, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous general-purpose inputs |
| bus_addr | input | 3 | Register word offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
Two functions can hit the same pending bit in one cycle: event detection setting it and an acknowledge write clearing it. The bench raises a pin in rising mode. It then counts synchronizer stages so that the acknowledge strobe lands on exactly the edge where the detector reports the edge. It then reads the pending register and expects the bit to be set. A second acknowledge, issued after the pin is quiet, must then clear the bit. This shows that the first write was overridden and not simply lost.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam logic [ADDR_W-1:0] ADDR_EN    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PEND  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ACK   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MSET  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MCLR  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_MODE0 = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_MODE1 = 3'd7;

endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  output logic       hit_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   cur;
  logic                   match;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  always_comb begin
    unique case (mode_i)
      TRIG_FALL: match = ~cur & last_q;
      TRIG_RISE: match = cur & ~last_q;
      TRIG_LOW:  match = ~cur;
      TRIG_HIGH: match = cur;
      TRIG_BOTH: match = cur ^ last_q;
      default:   match = 1'b0;
    endcase
  end

  assign hit_o = en_i & match;

  // R6: codes above 4 never report an event
  p_bad_code_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i > 3'd4) |-> !hit_o);

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int NPINS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pend_i,
  input  logic [NPINS-1:0] mask_i,
  output logic             irq_o
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_i & ~mask_i);
  end

  assign irq_o = irq_q;

  // R10: a fully masked bank cannot raise the line on the next cycle
  p_all_masked_r10: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '1) |=> !irq_o);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);

  localparam int PER_BANK = DW / 4;
  localparam int SLOTS    = 2 * PER_BANK;

  logic [NPINS-1:0] en_q, pend_q, mask_q, hit;
  logic [2:0]       mode_q [NPINS];
  logic [SLOTS-1:0][3:0] mode_pad;
  logic [DW-1:0]    rd_next, rdata_q;
  logic [NPINS-1:0] wbits;
  logic             w_en, w_ack, w_mset, w_mclr;

  assign wbits  = bus_wdata[NPINS-1:0];
  assign w_en   = bus_we && (bus_addr == ADDR_EN);
  assign w_ack  = bus_we && (bus_addr == ADDR_ACK);
  assign w_mset = bus_we && (bus_addr == ADDR_MSET);
  assign w_mclr = bus_we && (bus_addr == ADDR_MCLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      if (w_en) en_q <= wbits;
      pend_q <= (pend_q & ~(w_ack ? wbits : '0)) | hit;
      if (w_mset)      mask_q <= mask_q | wbits;
      else if (w_mclr) mask_q <= mask_q & ~wbits;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int BANK = i / PER_BANK;
    localparam int POS  = 4 * (i % PER_BANK);
    localparam logic [ADDR_W-1:0] MADDR = (BANK == 0) ? ADDR_MODE0 : ADDR_MODE1;

    always_ff @(posedge clk) begin
      if (rst)                              mode_q[i] <= 3'd0;
      else if (bus_we && bus_addr == MADDR) mode_q[i] <= bus_wdata[POS +: 3];
    end

    gpio_irq_pin #(.SYNC_STAGES(2)) u_pin (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_i[i]),
      .en_i   (en_q[i]),
      .mode_i (mode_q[i]),
      .hit_o  (hit[i])
    );
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    if (j < NPINS) begin : g_used
      assign mode_pad[j] = {1'b0, mode_q[j]};
    end else begin : g_empty
      assign mode_pad[j] = 4'd0;
    end
  end

  always_comb begin
    rd_next = '0;
    unique case (bus_addr)
      ADDR_EN:    rd_next[NPINS-1:0] = en_q;
      ADDR_PEND:  rd_next[NPINS-1:0] = pend_q;
      ADDR_MASK:  rd_next[NPINS-1:0] = mask_q;
      ADDR_MODE0: rd_next = mode_pad[PER_BANK-1:0];
      ADDR_MODE1: rd_next = mode_pad[SLOTS-1:PER_BANK];
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

  gpio_irq_combine #(.NPINS(NPINS)) u_comb (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  // R7: a pending bit only rises for a pin that was enabled
  p_enable_gate_r7: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R8: acknowledged bits without a concurrent event are cleared
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    w_ack |=> ((pend_q & $past(wbits) & ~$past(hit)) == '0));

  // R11: an event coinciding with an acknowledge survives
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    w_ack |=> ((pend_q & $past(hit)) == $past(hit)));

  // R9: mask set and clear take effect on the written bits
  p_mask_set_r9: assert property (@(posedge clk) disable iff (rst)
    w_mset |=> ((mask_q & $past(wbits)) == $past(wbits)));
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (rst)
    w_mclr |=> ((mask_q & $past(wbits)) == '0));

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int N  = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pins = '0;
  logic [2:0]    addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] mode0_sh = '0, mode1_sh = '0;
  logic [N-1:0] en_sh = '0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N), .DW(DW)) dut (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic cfg(input int p, input logic [2:0] code, input bit enable);
    if (p < 8) begin
      mode0_sh[4*p +: 4] = {1'b0, code};
      wr(3'd6, mode0_sh);
    end else begin
      mode1_sh[4*(p-8) +: 4] = {1'b0, code};
      wr(3'd7, mode1_sh);
    end
    if (enable) en_sh[p] = 1'b1;
    wr(3'd0, 32'(en_sh));
    wr(3'd5, 32'(1) << p);
    wr(3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic cleanup();
    pins = '0;
    settle();
    en_sh = '0; mode0_sh = '0; mode1_sh = '0;
    wr(3'd0, 0); wr(3'd6, 0); wr(3'd7, 0);
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    rd(3'd0, d); chk("R1 enable", d, 0);
    rd(3'd1, d); chk("R1 pending", d, 0);
    rd(3'd3, d); chk("R1 mask", d, 32'h0000_0FFF);
    rd(3'd6, d); chk("R1 mode0", d, 0);
    rd(3'd7, d); chk("R1 mode1", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, d); chk("R12 bank0 fields", d, 32'h7777_7777);
    wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, d); chk("R12 bank1 fields", d, 32'h0000_7777);
    wr(3'd7, 32'h0000_0530); rd(3'd7, d); chk("R12 bank1 pattern", d, 32'h0000_0530);
    cleanup();
  endtask

  task automatic t_rise();
    logic [31:0] d;
    cfg(0, 3'd1, 1);
    @(negedge clk); pins[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 irq not before 4th edge", 32'(irq), 0);
    @(negedge clk);
    chk("R10 irq on 4th edge", 32'(irq), 1);
    rd(3'd1, d); chk("R2 rise pending", d, 32'h1);
    wr(3'd2, 32'h1); rd(3'd1, d); chk("R8 ack clears", d, 0);
    settle(); chk("R10 irq drops after ack", 32'(irq), 0);
    pins[0] = 1'b0; settle();
    rd(3'd1, d); chk("R2 fall ignored", d, 0);
    cleanup();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    cfg(1, 3'd0, 1);
    pins[1] = 1'b1; settle();
    rd(3'd1, d); chk("R3 rise ignored", d, 0);
    pins[1] = 1'b0; settle();
    rd(3'd1, d); chk("R3 fall pending", d, 32'h2);
    cleanup();
  endtask

  task automatic t_both();
    logic [31:0] d;
    cfg(2, 3'd4, 1);
    pins[2] = 1'b1; settle();
    rd(3'd1, d); chk("R4 rise pending", d, 32'h4);
    wr(3'd2, 32'h4);
    pins[2] = 1'b0; settle();
    rd(3'd1, d); chk("R4 fall pending", d, 32'h4);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] d;
    cfg(9, 3'd3, 1);
    pins[9] = 1'b1; settle();
    rd(3'd1, d); chk("R5 high level pending", d, 32'h200);
    wr(3'd2, 32'h200); rd(3'd1, d); chk("R5 high level re-sets", d, 32'h200);
    pins[9] = 1'b0; settle();
    wr(3'd2, 32'h200); rd(3'd1, d); chk("R5 high ack sticks", d, 0);
    pins[3] = 1'b1; settle();
    cfg(3, 3'd2, 1);
    rd(3'd1, d); chk("R5 low level idle", d, 0);
    pins[3] = 1'b0; settle();
    wr(3'd2, 32'h8); rd(3'd1, d); chk("R5 low level re-sets", d, 32'h8);
    pins[3] = 1'b1; settle();
    wr(3'd2, 32'h8); rd(3'd1, d); chk("R5 low ack sticks", d, 0);
    cleanup();
  endtask

  task automatic t_bad();
    logic [31:0] d;
    for (int c = 5; c < 8; c++) begin
      cfg(4, 3'(c), 1);
      pins[4] = 1'b1; settle();
      pins[4] = 1'b0; settle();
      rd(3'd1, d); chk("R6 unused code silent", d, 0);
    end
    cleanup();
  endtask

  task automatic t_disable();
    logic [31:0] d;
    cfg(5, 3'd1, 0);
    wr(3'd0, 32'h0000_0A5A); rd(3'd0, d); chk("R7 enable readback", d, 32'h0000_0A5A);
    pins[5] = 1'b1; settle();
    rd(3'd1, d); chk("R7 disabled pin silent", d, 0);
    cleanup();
  endtask

  task automatic t_ack_zero();
    logic [31:0] d;
    cfg(0, 3'd1, 1);
    cfg(2, 3'd1, 1);
    pins[0] = 1'b1; pins[2] = 1'b1; settle();
    wr(3'd2, 32'h1); rd(3'd1, d); chk("R8 zero bits kept", d, 32'h4);
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    cfg(6, 3'd1, 1);
    wr(3'd4, 32'h40); rd(3'd3, d); chk("R9 mask set", d, 32'h0FFF);
    wr(3'd5, 32'hFFF); wr(3'd4, 32'h40);
    wr(3'd4, 32'h0); rd(3'd3, d); chk("R9 zero set no effect", d, 32'h40);
    pins[6] = 1'b1; settle();
    rd(3'd1, d); chk("R10 latched while masked", d, 32'h40);
    chk("R10 masked irq low", 32'(irq), 0);
    wr(3'd5, 32'h40); rd(3'd3, d); chk("R9 mask clear", d, 0);
    chk("R10 unmasked irq high", 32'(irq), 1);
    cleanup();
  endtask

  task automatic t_race();
    logic [31:0] d;
    cfg(7, 3'd1, 1);
    @(negedge clk); pins[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd2; wdata = 32'h80;
    @(negedge clk); we = 1'b0;
    rd(3'd1, d); chk("R11 set wins", d, 32'h80);
    wr(3'd2, 32'h80); rd(3'd1, d); chk("R11 later ack clears", d, 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_bad();
    t_disable();
    t_ack_zero();
    t_mask();
    t_race();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule